// File: doc/BRIEF.md
# Aging-Counter Replacement Selector

This block keeps approximate recency information for a fixed pool of memory frames and names the frame that should give way when a new page has to come in. Each frame carries a residency bit and a small age counter. Using a frame (a reference or a fresh load) resets its age. A periodic tick makes every resident frame one step older. The frame whose age is highest is therefore the one touched longest ago, and it is offered as the victim.

Empty frames always take priority over eviction. If any frame holds no page, the lowest-numbered empty frame is named and a free flag is raised. The victim choice is a combinational function of the stored state, so it follows the registers with no extra cycle of delay. Address translation, page tables, data movement and fault handling live elsewhere.

Top module: `lru_age_sel`

## Requirements
- R1: After a synchronous active-high reset, every frame is empty and every age is zero: `victim_idx` reads 0 and `free_avail` reads 1.
- R2: A reference strobe with a frame index clears that frame's age to zero in the next cycle. The frame's residency is unchanged.
- R3: On a cycle with `age_tick` high, every resident frame that is not being used in that cycle gains one on its age.
- R4: An age that has reached its maximum (all ones over `AGE_W` bits) stays there on further ticks and never wraps to zero.
- R5: When every frame is resident, `victim_idx` names a frame whose age is not smaller than any other frame's age, and `free_avail` is 0.
- R6: While at least one frame is empty, `victim_idx` names the lowest-numbered empty frame, ahead of any age comparison, and `free_avail` is 1.
- R7: A load strobe with a frame index marks that frame resident and clears its age to zero in the next cycle. A load counts as a use.
- R8: When several resident frames share the largest age, the lowest-numbered of them is the victim.
- R9: If a frame is used and `age_tick` is high in the same cycle, the clear wins and the frame's age ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference strobe for frame `ref_idx` |
| ref_idx | input | $clog2(FRAMES) | Frame being referenced |
| age_tick | input | 1 | Periodic aging pulse |
| load_en | input | 1 | Load strobe for frame `load_idx` |
| load_idx | input | $clog2(FRAMES) | Frame receiving a new page |
| victim_idx | output | $clog2(FRAMES) | Frame proposed for replacement |
| free_avail | output | 1 | High when some frame is empty |

## Verification
The properties assume that frame indices name real frames and that a reference and a load may target the same or different frames in one cycle, with either being a use. They hold regardless of how densely ticks arrive. The stimulus first fills the pool one frame at a time, then ages, references and saturates it along a scripted path. After that it runs a long random mix of references, loads, ticks and occasional resets. Indices are always drawn within the frame count. A behavioural model built on integer arrays predicts the victim and the free flag on every cycle.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

    localparam int FRAMES_DEFAULT = 8;
    localparam int AGE_W_DEFAULT  = 4;

    // Which rule produced the victim index
    typedef enum logic {
        PICK_EMPTY  = 1'b0,
        PICK_OLDEST = 1'b1
    } pick_src_e;

endpackage

// File: rtl/age_frame_slot.sv
module age_frame_slot #(
    parameter int AGE_W = lru_age_pkg::AGE_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_hit,
    input  logic             load_hit,
    input  logic             tick,
    output logic             valid_o,
    output logic [AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic             valid;
        logic [AGE_W-1:0] age;
    } slot_t;

    slot_t cur;
    logic  touched;

    assign touched = use_hit | load_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (load_hit)
                cur.valid <= 1'b1;
            if (touched)
                cur.age <= '0;
            else if (tick && cur.valid && cur.age != AGE_MAX)
                cur.age <= cur.age + 1'b1;
        end
    end

    assign valid_o = cur.valid;
    assign age_o   = cur.age;

    // R2 / R7 / R9: any use leaves the age at zero, tick or not
    a_r9_use_clears: assert property (@(posedge clk) disable iff (rst)
        touched |=> (age_o == '0));

    // R7: a load makes the frame resident
    a_r7_load_valid: assert property (@(posedge clk) disable iff (rst)
        load_hit |=> valid_o);

    // R3: a tick on an untouched resident frame below the ceiling adds one
    a_r3_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !touched && valid_o && age_o != AGE_MAX) |=> (age_o == $past(age_o) + 1'b1));

    // R4: the ceiling holds until the frame is used
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!touched && age_o == AGE_MAX) |=> (age_o == AGE_MAX));

endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
    parameter int FRAMES = lru_age_pkg::FRAMES_DEFAULT,
    parameter int AGE_W  = lru_age_pkg::AGE_W_DEFAULT,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0]            valid_i,
    input  logic [FRAMES-1:0][AGE_W-1:0] ages_i,
    output logic [IDX_W-1:0]             victim_o,
    output logic                         free_o
);

    import lru_age_pkg::*;

    pick_src_e        src;
    logic [IDX_W-1:0] empty_idx;
    logic [IDX_W-1:0] old_idx;
    logic [AGE_W-1:0] old_age;
    logic             any_empty;

    // Lowest-numbered empty frame: scan downward so the lowest wins
    always_comb begin
        any_empty = 1'b0;
        empty_idx = '0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_empty = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
    end

    // Largest age, strict compare keeps the lowest index on ties
    always_comb begin
        old_idx = '0;
        old_age = ages_i[0];
        for (int i = 1; i < FRAMES; i++) begin
            if (ages_i[i] > old_age) begin
                old_age = ages_i[i];
                old_idx = IDX_W'(i);
            end
        end
    end

    assign src      = any_empty ? PICK_EMPTY : PICK_OLDEST;
    assign victim_o = (src == PICK_EMPTY) ? empty_idx : old_idx;
    assign free_o   = (src == PICK_EMPTY);

endmodule

// File: rtl/lru_age_sel.sv
module lru_age_sel #(
    parameter int FRAMES = lru_age_pkg::FRAMES_DEFAULT,
    parameter int AGE_W  = lru_age_pkg::AGE_W_DEFAULT,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_en,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             age_tick,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    output logic [IDX_W-1:0] victim_idx,
    output logic             free_avail
);

    logic [FRAMES-1:0]            frame_valid;
    logic [FRAMES-1:0][AGE_W-1:0] frame_age;

    for (genvar g = 0; g < FRAMES; g++) begin : g_slot
        logic use_hit;
        logic load_hit;

        assign use_hit  = ref_en  && (ref_idx  == IDX_W'(g));
        assign load_hit = load_en && (load_idx == IDX_W'(g));

        age_frame_slot #(.AGE_W(AGE_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .use_hit  (use_hit),
            .load_hit (load_hit),
            .tick     (age_tick),
            .valid_o  (frame_valid[g]),
            .age_o    (frame_age[g])
        );
    end

    victim_pick #(.FRAMES(FRAMES), .AGE_W(AGE_W)) u_pick (
        .valid_i  (frame_valid),
        .ages_i   (frame_age),
        .victim_o (victim_idx),
        .free_o   (free_avail)
    );

    // True if some frame beats the chosen victim on age, or ties it at a lower index
    function automatic logic better_exists(input logic [IDX_W-1:0] v);
        logic found = 1'b0;
        for (int j = 0; j < FRAMES; j++) begin
            if (frame_age[j] > frame_age[v])
                found = 1'b1;
            if (j < int'(v) && frame_age[j] == frame_age[v])
                found = 1'b1;
        end
        return found;
    endfunction

    // R6: a free flag always points at an empty frame with no empty frame below it
    a_r6_empty_first: assert property (@(posedge clk) disable iff (rst)
        free_avail |-> (!frame_valid[victim_idx] &&
                        ((frame_valid & ((FRAMES'(1) << victim_idx) - FRAMES'(1))) ==
                         ((FRAMES'(1) << victim_idx) - FRAMES'(1)))));

    // R6: no free flag means the pool is full
    a_r6_full_flag: assert property (@(posedge clk) disable iff (rst)
        !free_avail |-> (&frame_valid));

    // R5 / R8: the victim is the oldest, lowest index among equals
    a_r8_oldest_lowest: assert property (@(posedge clk) disable iff (rst)
        !free_avail |-> !better_exists(victim_idx));

    // R1: the cycle after reset the pool is empty and frame 0 is offered
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (free_avail && victim_idx == '0));

endmodule

// File: tb/lru_age_sel_test.sv
module lru_age_sel_test;

    localparam int CLK_PERIOD = 10;
    localparam int NF    = 8;
    localparam int AW    = 4;
    localparam int IW    = $clog2(NF);
    localparam int AMAX  = (1 << AW) - 1;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          ref_en;
    logic [IW-1:0] ref_idx;
    logic          age_tick;
    logic          load_en;
    logic [IW-1:0] load_idx;
    logic [IW-1:0] victim_idx;
    logic          free_avail;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string phase  = "R1 reset state";

    int m_age [NF];
    bit m_val [NF];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lru_age_sel #(.FRAMES(NF), .AGE_W(AW)) uut (
        .clk        (clk),
        .rst        (rst),
        .ref_en     (ref_en),
        .ref_idx    (ref_idx),
        .age_tick   (age_tick),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .victim_idx (victim_idx),
        .free_avail (free_avail)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<=%0d", cycles, WATCHDOG);
            report();
            $finish;
        end
    end

    // Next-state of the reference model for the inputs about to be clocked
    task automatic model_step(input bit r, input bit re, input int ri,
                              input bit t, input bit le, input int li);
        for (int i = 0; i < NF; i++) begin
            bit used;
            used = (re && ri == i) || (le && li == i);
            if (r) begin
                m_val[i] = 0;
                m_age[i] = 0;
            end else begin
                if (used)
                    m_age[i] = 0;
                else if (t && m_val[i] && m_age[i] < AMAX)
                    m_age[i] = m_age[i] + 1;
                if (le && li == i)
                    m_val[i] = 1;
            end
        end
    endtask

    task automatic compare();
        int    ev;
        bit    ef;
        int    top_cnt;
        string tag;
        ev = -1;
        ef = 0;
        for (int i = 0; i < NF; i++)
            if (!m_val[i] && ev < 0) begin
                ev = i;
                ef = 1;
            end
        top_cnt = 0;
        if (!ef) begin
            ev = 0;
            for (int i = 1; i < NF; i++)
                if (m_age[i] > m_age[ev]) ev = i;
            for (int i = 0; i < NF; i++)
                if (m_age[i] == m_age[ev]) top_cnt++;
        end
        if (ef)               tag = "R6";
        else if (top_cnt > 1) tag = "R8";
        else                  tag = "R5";
        checks++;
        if (int'(victim_idx) != ev || free_avail != ef) begin
            fails++;
            $display("FAIL %s [%s] victim=%0d free=%0d expected victim=%0d free=%0d",
                     tag, phase, victim_idx, free_avail, ev, ef);
        end
    endtask

    task automatic cyc(input bit r, input bit re, input int ri,
                       input bit t, input bit le, input int li);
        rst      = r;
        ref_en   = re;
        ref_idx  = IW'(ri);
        age_tick = t;
        load_en  = le;
        load_idx = IW'(li);
        model_step(r, re, ri, t, le, li);
        @(negedge clk);
        compare();
    endtask

    initial begin
        for (int i = 0; i < NF; i++) begin
            m_age[i] = 0;
            m_val[i] = 0;
        end
        rst = 1; ref_en = 0; ref_idx = '0; age_tick = 0; load_en = 0; load_idx = '0;

        // R1: reset leaves an empty pool, frame 0 offered
        phase = "R1 reset state";
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);

        // R7: fill frames in order with a tick alongside each load
        phase = "R7 fill with load";
        for (int i = 0; i < NF; i++)
            cyc(0, 0, 0, 1, 1, i);

        // R3: ticks age the full pool; frame 0 is oldest
        phase = "R3 aging full pool";
        for (int k = 0; k < 3; k++)
            cyc(0, 0, 0, 1, 0, 0);

        // R2: referencing the oldest frame moves the choice on
        phase = "R2 reference clears";
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);

        // R9: reference and tick together on frame 1
        phase = "R9 clear beats tick";
        cyc(0, 1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);

        // R4: long run of ticks saturates every age, tie resolves low (R8)
        phase = "R4 saturation tie";
        for (int k = 0; k < 2 * AMAX; k++)
            cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);

        // R7: reloading a resident frame clears its age
        phase = "R7 reload clears";
        cyc(0, 0, 0, 1, 1, 1);
        cyc(0, 0, 0, 0, 0, 0);

        // R1: mid-run reset empties everything again
        phase = "R1 reset mid-run";
        cyc(1, 1, 2, 1, 1, 3);
        cyc(0, 0, 0, 1, 0, 0);

        // Random mix of all stimulus
        phase = "R2 R3 R7 R9 random mix";
        for (int k = 0; k < 4000; k++) begin
            bit r;
            r = ($urandom_range(0, 299) == 0);
            cyc(r, $urandom_range(0, 1) == 1, int'($urandom_range(0, NF - 1)),
                $urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0,
                int'($urandom_range(0, NF - 1)));
        end

        done = 1;
        report();
        $finish;
    end

endmodule